// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit core and a data memory that is organised in words with big-endian byte order: the byte at the lowest address is the most significant byte of the word. For every access request it forms the effective address (a base register plus a sign-extended 16-bit offset, with 32-bit wraparound). It checks the address against the access size and drives a word-aligned memory address, per-lane byte enables and lane-steered write data. For loads it takes the word that comes back from memory and builds the register result. That covers byte and halfword extraction with sign or zero extension, full words, the partial-register merges of the unaligned left and right word loads, and the load-upper-immediate form, which needs no memory access.

The unit has two pipeline steps. A request presented with `req_valid` in one cycle shows up on the memory-side outputs after the next rising edge. The memory is expected to return `rd_word` for that address during that following cycle. The merged register value then appears on `ld_data` with `ld_valid` one further edge later. The old value of the destination register travels along with the request (`req_rt`), so a new request may be presented in every cycle.

Top module: `lsu_align_unit`

## Requirements
- R1: While `rst_n` is low, `mem_be`, `mem_write`, `mem_read`, `align_fault` and `ld_valid` are all zero.
- R2: The effective address is `req_base` plus `req_imm` sign-extended to 32 bits, modulo 2^32. One edge after the request, `mem_addr` equals this address with bits 1:0 cleared.
- R3: `req_op` codes: 0 signed byte load, 1 unsigned byte load, 2 signed halfword load, 3 unsigned halfword load, 4 word load, 5 left word load, 6 right word load, 7 load upper immediate, 8 byte store, 9 halfword store, 10 word store. `mem_be[3]` covers `mem_wdata[31:24]`, the byte at offset 0 of the word, down to `mem_be[0]` for offset 3. Let k be the effective address bits 1:0. Byte accesses enable lane k only. Halfword accesses enable lanes k and k+1. Word accesses enable all four lanes. The left word load enables lanes k..3 and the right word load enables lanes 0..k. `mem_read` and `mem_write` are never high together.
- R4: The byte store places bits 7:0 of `req_rt` in lane k. The halfword store places bits 15:8 in lane k and bits 7:0 in lane k+1. The word store places `req_rt` unchanged. Unused lanes of `mem_wdata` are zero.
- R5: Halfword accesses (codes 2, 3, 9) fault when address bit 0 is 1. Word accesses (codes 4, 10) fault when bits 1:0 are nonzero. A fault raises `align_fault` for one cycle with all enables zero, no `mem_read`, no `mem_write` and no later `ld_valid`.
- R6: Byte and halfword loads return the addressed byte or halfword from `rd_word`. Codes 0 and 2 sign-extend it to 32 bits and codes 1 and 3 zero-extend it.
- R7: The word load returns `rd_word` unchanged.
- R8: The left word load at offset k writes memory bytes k..3 into register bytes from the most significant down and keeps the low k bytes of the old register value.
- R9: The right word load at offset k writes memory bytes 0..k into the low k+1 register bytes and keeps the remaining upper bytes of the old register value.
- R10: Load upper immediate returns `req_imm` in bits 31:16 and zero below. It asserts no enable and no `mem_read`.
- R11: Codes 11 to 15, and cycles with `req_valid` low, produce no enable, no `mem_read`, no `mem_write`, no fault and no `ld_valid`.
- R12: A load result appears exactly two edges after its request. It uses the old register value given with that request, even when a new request is already being issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present this cycle |
| req_op | input | 4 | Access code (see R3) |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed address offset; the immediate for load upper |
| req_rt | input | 32 | Store data, or the old destination register value for loads |
| rd_word | input | 32 | Memory word read at `mem_addr` |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_write | output | 1 | Store issued |
| mem_read | output | 1 | Load issued |
| align_fault | output | 1 | Misaligned halfword or word access |
| ld_valid | output | 1 | `ld_data` holds a new register result |
| ld_data | output | 32 | Merged register load value |

## Verification
Issuing a new request in the cycle after a load means the merge of the older load and the steering of the newer access happen in the same cycle. The merge then has to use the old register value from its own request, not the `req_rt` on the bus at that moment. The bench provokes this with back-to-back requests in every cycle, over every code and every byte offset, and then with a long mixed random stream. In each overlapping cycle a reference model judges both results: memory-side outputs for the newer request and the merged value for the older one.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LB  = 4'd0,
        OP_LBU = 4'd1,
        OP_LH  = 4'd2,
        OP_LHU = 4'd3,
        OP_LW  = 4'd4,
        OP_LWL = 4'd5,
        OP_LWR = 4'd6,
        OP_LUI = 4'd7,
        OP_SB  = 4'd8,
        OP_SH  = 4'd9,
        OP_SW  = 4'd10
    } mem_op_e;

    typedef enum logic [2:0] {
        SZ_NONE,
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD,
        SZ_LEFT,
        SZ_RIGHT
    } acc_size_e;

    function automatic acc_size_e op_size(input logic [OP_W-1:0] op);
        case (op)
            OP_LB, OP_LBU, OP_SB: return SZ_BYTE;
            OP_LH, OP_LHU, OP_SH: return SZ_HALF;
            OP_LW, OP_SW:         return SZ_WORD;
            OP_LWL:               return SZ_LEFT;
            OP_LWR:               return SZ_RIGHT;
            default:              return SZ_NONE;
        endcase
    endfunction

    function automatic logic op_reads(input logic [OP_W-1:0] op);
        return op <= OP_LWR;
    endfunction

    function automatic logic op_writes(input logic [OP_W-1:0] op);
        return (op == OP_SB) || (op == OP_SH) || (op == OP_SW);
    endfunction

    function automatic logic op_returns(input logic [OP_W-1:0] op);
        return op <= OP_LUI;
    endfunction

    function automatic logic op_unsigned(input logic [OP_W-1:0] op);
        return (op == OP_LBU) || (op == OP_LHU);
    endfunction

endpackage

// File: rtl/lsu_addr_check.sv
module lsu_addr_check
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IMM_W     = 16,
    parameter int LANE_BITS = 2
) (
    input  logic [OP_W-1:0]      op,
    input  logic [ADDR_W-1:0]    base,
    input  logic [IMM_W-1:0]     imm,
    output logic [ADDR_W-1:0]    ea,
    output logic [LANE_BITS-1:0] lane,
    output acc_size_e            size,
    output logic                 fault
);
    localparam int EXT_W = ADDR_W - IMM_W;

    always_comb begin
        // wraparound add, no overflow detection
        ea   = base + {{EXT_W{imm[IMM_W-1]}}, imm};
        lane = ea[LANE_BITS-1:0];
        size = op_size(op);
        unique case (size)
            SZ_HALF: fault = lane[0];
            SZ_WORD: fault = |lane;
            default: fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_align_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LANE_BITS = 2
) (
    input  acc_size_e              size,
    input  logic                   is_store,
    input  logic                   fault,
    input  logic [LANE_BITS-1:0]   lane,
    input  logic [DATA_W-1:0]      rt,
    output logic [DATA_W/8-1:0]    be,
    output logic [DATA_W-1:0]      wdata
);
    localparam int NB = DATA_W / 8;

    // i is the big-endian byte index: 0 = lowest address = most significant
    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam int HI = DATA_W - 1 - 8 * i;
        localparam logic [LANE_BITS-1:0] IDX = LANE_BITS'(i);
        logic       hit;
        logic [7:0] src;

        always_comb begin
            unique case (size)
                SZ_BYTE:  hit = (IDX == lane);
                SZ_HALF:  hit = (IDX == lane) || (IDX == lane + LANE_BITS'(1));
                SZ_WORD:  hit = 1'b1;
                SZ_LEFT:  hit = (IDX >= lane);
                SZ_RIGHT: hit = (IDX <= lane);
                default:  hit = 1'b0;
            endcase
            unique case (size)
                SZ_BYTE: src = rt[7:0];
                SZ_HALF: src = (IDX == lane) ? rt[15:8] : rt[7:0];
                SZ_WORD: src = rt[HI -: 8];
                default: src = 8'h00;
            endcase
        end

        assign be[NB-1-i]     = hit && !fault;
        assign wdata[HI -: 8] = (hit && is_store && !fault) ? src : 8'h00;
    end
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
    import lsu_align_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LANE_BITS = 2
) (
    input  acc_size_e              size,
    input  logic                   is_unsigned,
    input  logic                   is_lui,
    input  logic [LANE_BITS-1:0]   lane,
    input  logic [DATA_W-1:0]      held,
    input  logic [DATA_W-1:0]      rd_word,
    output logic [DATA_W-1:0]      value
);
    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] keep_left;
    logic [DATA_W-1:0] keep_right;

    // per-byte masks of the old register bytes that survive a partial load
    for (genvar i = 0; i < NB; i++) begin : g_mask
        localparam int HI = DATA_W - 1 - 8 * i;
        assign keep_left[HI -: 8]  = ((i + int'(lane)) > (NB - 1)) ? 8'hFF : 8'h00;
        assign keep_right[HI -: 8] = ((i + int'(lane)) < (NB - 1)) ? 8'hFF : 8'h00;
    end

    int          byte_sh;
    int          half_sh;
    logic [7:0]  byte_v;
    logic [15:0] half_v;
    logic        ext_b;
    logic        ext_h;

    always_comb begin
        byte_sh = 8 * (NB - 1 - int'(lane));
        half_sh = 8 * (NB - 2 - int'(lane));
        if (half_sh < 0) begin
            half_sh = 0;
        end
        byte_v = 8'(rd_word >> byte_sh);
        half_v = 16'(rd_word >> half_sh);
        ext_b  = byte_v[7] && !is_unsigned;
        ext_h  = half_v[15] && !is_unsigned;
        if (is_lui) begin
            value = held;
        end else begin
            unique case (size)
                SZ_BYTE:  value = {{(DATA_W-8){ext_b}}, byte_v};
                SZ_HALF:  value = {{(DATA_W-16){ext_h}}, half_v};
                SZ_WORD:  value = rd_word;
                SZ_LEFT:  value = (rd_word << (8 * int'(lane))) | (held & keep_left);
                SZ_RIGHT: value = (rd_word >> byte_sh) | (held & keep_right);
                default:  value = held;
            endcase
        end
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [OP_W-1:0]       req_op,
    input  logic [ADDR_W-1:0]     req_base,
    input  logic [IMM_W-1:0]      req_imm,
    input  logic [DATA_W-1:0]     req_rt,
    input  logic [DATA_W-1:0]     rd_word,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  mem_write,
    output logic                  mem_read,
    output logic                  align_fault,
    output logic                  ld_valid,
    output logic [DATA_W-1:0]     ld_data
);
    localparam int NB        = DATA_W / 8;
    localparam int LANE_BITS = $clog2(NB);
    localparam int LOW_W     = DATA_W - IMM_W;

    // ---- issue step (combinational) ----
    logic [ADDR_W-1:0]    ea;
    logic [LANE_BITS-1:0] lane;
    acc_size_e            size;
    logic                 fault;
    logic [NB-1:0]        be_c;
    logic [DATA_W-1:0]    wd_c;

    lsu_addr_check #(
        .ADDR_W(ADDR_W), .IMM_W(IMM_W), .LANE_BITS(LANE_BITS)
    ) u_addr (
        .op(req_op), .base(req_base), .imm(req_imm),
        .ea(ea), .lane(lane), .size(size), .fault(fault)
    );

    lsu_store_steer #(
        .DATA_W(DATA_W), .LANE_BITS(LANE_BITS)
    ) u_store (
        .size(size), .is_store(op_writes(req_op)), .fault(fault),
        .lane(lane), .rt(req_rt), .be(be_c), .wdata(wd_c)
    );

    // ---- issue step registers ----
    logic [ADDR_W-1:LANE_BITS] s1_addr_hi;
    logic                      lc_valid;
    acc_size_e                 lc_size;
    logic                      lc_unsigned;
    logic                      lc_lui;
    logic [LANE_BITS-1:0]      lc_lane;
    logic [DATA_W-1:0]         lc_held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_write   <= 1'b0;
            mem_read    <= 1'b0;
            align_fault <= 1'b0;
            mem_be      <= '0;
            mem_wdata   <= '0;
            s1_addr_hi  <= '0;
            lc_valid    <= 1'b0;
            lc_size     <= SZ_NONE;
            lc_unsigned <= 1'b0;
            lc_lui      <= 1'b0;
            lc_lane     <= '0;
            lc_held     <= '0;
        end else begin
            mem_write   <= req_valid && op_writes(req_op) && !fault;
            mem_read    <= req_valid && op_reads(req_op) && !fault;
            align_fault <= req_valid && fault;
            mem_be      <= req_valid ? be_c : '0;
            mem_wdata   <= req_valid ? wd_c : '0;
            lc_valid    <= req_valid && op_returns(req_op) && !fault;
            if (req_valid) begin
                s1_addr_hi  <= ea[ADDR_W-1:LANE_BITS];
                lc_size     <= size;
                lc_unsigned <= op_unsigned(req_op);
                lc_lui      <= (req_op == OP_LUI);
                lc_lane     <= lane;
                lc_held     <= (req_op == OP_LUI) ? {req_imm, {LOW_W{1'b0}}} : req_rt;
            end
        end
    end

    assign mem_addr = {s1_addr_hi, {LANE_BITS{1'b0}}};

    // ---- merge step ----
    logic [DATA_W-1:0] merged;

    lsu_load_merge #(
        .DATA_W(DATA_W), .LANE_BITS(LANE_BITS)
    ) u_load (
        .size(lc_size), .is_unsigned(lc_unsigned), .is_lui(lc_lui),
        .lane(lc_lane), .held(lc_held), .rd_word(rd_word), .value(merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= lc_valid;
            if (lc_valid) begin
                ld_data <= merged;
            end
        end
    end
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
    parameter int NB        = 4,
    parameter int LANE_BITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [NB-1:0]        mem_be,
    input logic [LANE_BITS-1:0] addr_lo,
    input logic                 mem_write,
    input logic                 mem_read,
    input logic                 align_fault,
    input logic                 ld_valid
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= 2'd0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (mem_be == '0 && !mem_write && !mem_read)); // R5

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_write && mem_read)); // R3

    AST_STORE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                       || $countones(mem_be) == NB)); // R4

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write || mem_read) |-> (addr_lo == '0)); // R2

    AST_FAULT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && align_fault) |-> $past(req_valid)); // R5

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && !$past(req_valid)) |-> (!mem_write && !mem_read && mem_be == '0)); // R11

    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && ld_valid) |-> $past(req_valid, 2)); // R12
endmodule

bind lsu_align_unit lsu_align_unit_chk #(
    .NB(NB), .LANE_BITS(LANE_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_be(mem_be),
    .addr_lo(mem_addr[LANE_BITS-1:0]), .mem_write(mem_write),
    .mem_read(mem_read), .align_fault(align_fault), .ld_valid(ld_valid)
);

// File: tb/lsu_align_unit_test.sv
module lsu_align_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_imm = '0;
    logic [31:0] req_rt = '0;
    logic [31:0] rd_word;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_write, mem_read, align_fault, ld_valid;
    logic [31:0] ld_data;

    int checks = 0;
    int errors = 0;
    logic run_chk = 1'b0;

    logic [31:0] mem_model [16];

    always #5 clk = ~clk;

    assign rd_word = mem_model[mem_addr[5:2]];

    lsu_align_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_imm(req_imm), .req_rt(req_rt), .rd_word(rd_word),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_write(mem_write), .mem_read(mem_read), .align_fault(align_fault),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic string optag(input int op);
        if (op <= 3) return "R6";
        if (op == 4) return "R7";
        if (op == 5) return "R8";
        if (op == 6) return "R9";
        if (op == 7) return "R10";
        if (op <= 10) return "R4";
        return "R11";
    endfunction

    // reference: register result of a load, byte by byte
    function automatic logic [31:0] ref_load(input int op, input int k, input logic [31:0] w,
                                             input logic [31:0] old, input logic [15:0] imm);
        logic [7:0] mb [4];
        logic [7:0] ob [4];
        logic [7:0] rb [4];
        logic [15:0] h;
        for (int i = 0; i < 4; i++) begin
            mb[i] = w[31-8*i -: 8];
            ob[i] = old[31-8*i -: 8];
        end
        h = {mb[k], mb[(k+1) % 4]};
        case (op)
            0: return {{24{mb[k][7]}}, mb[k]};
            1: return {24'h0, mb[k]};
            2: return {{16{h[15]}}, h};
            3: return {16'h0, h};
            4: return w;
            5: begin
                for (int i = 0; i < 4; i++) rb[i] = (i + k <= 3) ? mb[i+k] : ob[i];
                return {rb[0], rb[1], rb[2], rb[3]};
            end
            6: begin
                for (int i = 0; i < 4; i++) rb[i] = (i >= 3 - k) ? mb[i-(3-k)] : ob[i];
                return {rb[0], rb[1], rb[2], rb[3]};
            end
            7: return {imm, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    // expected state: e1 = memory-side outputs, e2 = load result
    logic        e1_valid, e1_wr, e1_rd, e1_fault, e1_ld;
    logic [3:0]  e1_be;
    logic [31:0] e1_wdata, e1_addr, e1_old;
    logic [15:0] e1_imm;
    int          e1_op, e1_k;
    logic        e2_valid;
    logic [31:0] e2_data;
    int          e2_op;

    always @(posedge clk or negedge rst_n) begin : model
        logic [31:0] ea;
        int op, k;
        logic flt, acc;
        logic [3:0] be;
        logic [31:0] wd;
        if (!rst_n) begin
            e1_valid <= 0; e1_wr <= 0; e1_rd <= 0; e1_fault <= 0; e1_ld <= 0;
            e1_be <= 0; e1_wdata <= 0; e1_addr <= 0; e1_old <= 0; e1_imm <= 0;
            e1_op <= 15; e1_k <= 0; e2_valid <= 0; e2_data <= 0; e2_op <= 15;
        end else begin
            e2_valid <= e1_ld;
            e2_op    <= e1_op;
            if (e1_ld)
                e2_data <= ref_load(e1_op, e1_k, mem_model[e1_addr[5:2]], e1_old, e1_imm);
            op  = int'(req_op);
            ea  = req_base + 32'($signed(req_imm));
            k   = int'(ea[1:0]);
            flt = req_valid && (((op == 2 || op == 3 || op == 9) && ea[0])
                               || ((op == 4 || op == 10) && k != 0));
            be  = 4'b0000;
            wd  = 32'h0;
            acc = req_valid && !flt && op <= 10 && op != 7;
            if (acc) begin
                for (int i = 0; i < 4; i++) begin
                    if (((op == 0 || op == 1 || op == 8) && i == k)
                        || ((op == 2 || op == 3 || op == 9) && (i == k || i == k + 1))
                        || op == 4 || op == 10
                        || (op == 5 && i >= k) || (op == 6 && i <= k))
                        be[3-i] = 1'b1;
                end
                if (op == 8) wd[31-8*k -: 8] = req_rt[7:0];
                if (op == 9) begin
                    wd[31-8*k -: 8] = req_rt[15:8];
                    wd[23-8*k -: 8] = req_rt[7:0];
                end
                if (op == 10) wd = req_rt;
            end
            e1_valid <= req_valid;
            e1_op    <= req_valid ? op : 15;
            e1_k     <= k;
            e1_fault <= flt;
            e1_be    <= be;
            e1_wdata <= wd;
            e1_addr  <= {ea[31:2], 2'b00};
            e1_rd    <= acc && op <= 6;
            e1_wr    <= acc && op >= 8;
            e1_ld    <= req_valid && !flt && op <= 7;
            e1_old   <= req_rt;
            e1_imm   <= req_imm;
        end
    end

    always @(negedge clk) begin : compare
        string t1;
        if (run_chk) begin
            t1 = e1_fault ? "R5" : optag(e1_op);
            chk(t1, "mem_write", 32'(mem_write), 32'(e1_wr));
            chk(t1, "mem_read", 32'(mem_read), 32'(e1_rd));
            chk("R5", "align_fault", 32'(align_fault), 32'(e1_fault));
            chk(e1_fault ? "R5" : "R3", "mem_be", 32'(mem_be), 32'(e1_be));
            if (e1_wr) chk("R4", "mem_wdata", mem_wdata, e1_wdata);
            if (e1_wr || e1_rd) chk("R2", "mem_addr", mem_addr, e1_addr);
            chk(optag(e2_op), "ld_valid", 32'(ld_valid), 32'(e2_valid));
            if (e2_valid) chk(optag(e2_op), "ld_data", ld_data, e2_data);
            if (e2_valid && (e1_wr || e1_rd))
                chk("R12", "ld_data during overlap", ld_data, e2_data);
        end
    end

    task automatic issue(input int op, input logic [31:0] base,
                         input logic [15:0] imm, input logic [31:0] rt);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 4'(op);
        req_base  = base;
        req_imm   = imm;
        req_rt    = rt;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++)
            mem_model[i] = 32'h8F3A_C215 + 32'(i) * 32'h1357_9BDF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "mem_be in reset", 32'(mem_be), 0);
        chk("R1", "mem_write in reset", 32'(mem_write), 0);
        chk("R1", "mem_read in reset", 32'(mem_read), 0);
        chk("R1", "align_fault in reset", 32'(align_fault), 0);
        chk("R1", "ld_valid in reset", 32'(ld_valid), 0);
        rst_n = 1'b1;
        run_chk = 1'b1;
        // every code at every byte offset, back to back (R3..R10, R12)
        for (int op = 0; op <= 10; op++)
            for (int k = 0; k < 4; k++)
                issue(op, 32'h0000_0010 + 32'(op * 4), 16'(k), 32'hC3A5_5A7E ^ 32'(op * 32'h0101_0101 + k));
        // undefined codes (R11)
        for (int op = 11; op <= 15; op++)
            issue(op, 32'h0000_0020, 16'h0000, 32'hFFFF_FFFF);
        idle(); idle(); idle();
        // address wraparound with negative and positive offsets (R2)
        issue(4, 32'h0000_0002, 16'hFFFE, 32'h0);
        issue(10, 32'hFFFF_FFFC, 16'h0008, 32'h1234_5678);
        issue(5, 32'h0000_0001, 16'hFFFF, 32'hAAAA_AAAA);
        issue(7, 32'h0, 16'h8001, 32'h5555_5555);
        idle(); idle();
        // mixed random stream with idles (R11, R12)
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 5) == 0) idle();
            else issue(int'($urandom_range(0, 12)), $urandom, 16'($urandom), $urandom);
        end
        idle(); idle(); idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule